// File: doc/BRIEF.md
# I2S Stereo Receive Channel

This block receives a serial stereo audio stream in standard I2S timing and turns it into left and right sample words in a receive FIFO. A host fetches these words with plain register reads. A DMA engine can fetch them the same way when it sees the request line raised. The FIFO holds 64 words of 32 bits, one channel sample per word, so it can keep up to 32 stereo pairs.

The channel runs in one of two clock modes. As clock master it divides its root clock by a programmable even ratio to form the bit clock, and it toggles word select after a programmed number of bit clocks per channel. As slave it takes bit clock, word select and data from outside through two-stage synchronizers. A configuration register holds the following fields:

- enable
- clock mode
- word-select polarity
- sample length (8 or 16 bits)
- a transfer-mode field that can disable the receive path

Software flushes the FIFO before each reception. Capture begins only at a word-select change seen after enable or flush. Software sees a pair in the FIFO only once both its left and right words are stored.

Top module: `i2s_rx_channel`

Register map:

| Address | Name | Access | Fields |
|---|---|---|---|
| 0 | config | read/write | [0] enable, [1] master, [2] polarity, [3] 16-bit, [5:4] mode, [15:8] halfDiv, [21:16] slotBits |
| 1 | FIFO status | read: [15:0] pair count, [16] overflow; write: bit 0 = flush | |
| 2 | receive data | read pops | |

Other addresses read as 0.

## Requirements
- R1: After reset the pair count and the overflow flag read 0, and dmaReq, sclkOut, wsOut and clkDrvEn are low.
- R2: Words are captured only while config bit 0 (enable) is set. The first word stored is the one that begins at the first word-select change after enable or flush. A pair always starts with a left word, and a right word with no left word before it is discarded.
- R3: The pair count (address 1, bits [15:0]) rises by one only when the right word of a pair has been stored. A completed left word whose right word has not completed is not counted.
- R4: Config bit 3 selects the sample length W: 1 gives 16 bits and 0 gives 8 bits. The data MSB is taken one bit clock after the word-select change, then the next W-1 bits, MSB first. The sample is stored in FIFO word bits [W-1:0] with all upper bits zero. Any further bits in the slot are ignored.
- R5: Config bit 2 sets the polarity. With 0, word select low marks the left channel. With 1, word select high marks the left channel.
- R6: Reading address 2 returns the oldest stored word and removes it, so the left word of a pair comes out before its right word. A read of an empty FIFO returns 0 and leaves the count unchanged.
- R7: dmaReq is high exactly while at least one complete pair (two words) is in the FIFO.
- R8: If a left word completes while fewer than two of the 64 words are free, that pair is dropped. The overflow flag (address 1, bit 16) is then set and stays set until a flush.
- R9: Writing 1 to bit 0 of address 1 empties the FIFO and clears the pair count, the overflow flag and any pending left word. It also makes capture wait again for the next word-select change.
- R10: In master mode (config bit 1 = 1), clkDrvEn is high and sclkOut has a period of 2 x halfDiv root clocks (halfDiv = config [15:8], at least 4). wsOut toggles on a falling sclkOut edge every slotBits bit clocks (slotBits = config [21:16]).
- R11: The mode field (config [5:4]) lets the receiver capture only at 01 (receive only) and 10 (transmit plus receive). At 00 and 11 no word is stored.
- R12: In slave mode, sclkIn, wsIn and sdIn are sampled through synchronizers, and sclkOut and clkDrvEn stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root audio clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid the cycle after regRd |
| sclkIn | input | 1 | External bit clock (slave mode) |
| wsIn | input | 1 | External word select (slave mode) |
| sdIn | input | 1 | Serial audio data |
| sclkOut | output | 1 | Generated bit clock (master mode) |
| wsOut | output | 1 | Generated word select (master mode) |
| clkDrvEn | output | 1 | High when the block drives the clocks |
| dmaReq | output | 1 | At least one stereo pair is ready |

## Verification
The bench runs a serial transmitter model in both clock modes. Each sample is derived from its channel and frame number, so a word in the wrong order, a shifted word or a mixed-up channel gives a different value.

Streams are sent in both polarities. The 8-bit runs use a 16-bit slot, which separates alignment and truncation errors from capture errors. Every stream ends with a lone left word, so an early pair count shows up. A second stream after a flush shows whether a stale pending left word leaks into the next pair. A long stream overfills the FIFO, and a disabled-mode stream checks that nothing is captured. Master runs measure the bit-clock period and the word-select spacing.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

  localparam int SAMPLE_W = 16;

  typedef struct packed {
    logic       active;
    logic       master;
    logic       leftHigh;
    logic       wide16;
    logic [1:0] mode;
    logic [7:0] halfDiv;
    logic [5:0] slotBits;
  } rxCfg_t;

  typedef struct packed {
    logic                pushLeft;
    logic                pushRight;
    logic                flush;
    logic                pop;
    logic [SAMPLE_W-1:0] sample;
  } rxStrobe_t;

  function automatic logic rxModeOn(input logic [1:0] mode);
    return (mode == 2'b01) || (mode == 2'b10);
  endfunction

endpackage

// File: rtl/i2s_rx_ctrl.sv
module i2s_rx_ctrl
  import i2s_rx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [CNT_W-1:0]  pairCount,
  input  logic              overflow,
  input  logic [DATA_W-1:0] fifoHead,
  input  logic              fifoEmpty,
  input  logic              sclkIn,
  input  logic              wsIn,
  input  logic              sdIn,
  output logic              sclkOut,
  output logic              wsOut,
  output logic              clkDrvEn,
  output rxStrobe_t         strobe
);

  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(2);
  localparam int SYNC_N = 2;
  localparam int BIT_W = $clog2(SAMPLE_W + 1);

  rxCfg_t cfg;
  logic   flushReq, popReq;
  logic   unusedWdata;

  assign unusedWdata = ^{regWdata[DATA_W-1:22], regWdata[7:6]};
  assign flushReq = regWr && (regAddr == A_STAT) && regWdata[0];
  assign popReq   = regRd && (regAddr == A_DATA) && !fifoEmpty;

  // configuration register and read-back
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg      <= '0;
      regRdata <= '0;
    end else begin
      if (regWr && regAddr == A_CFG) begin
        cfg.active   <= regWdata[0];
        cfg.master   <= regWdata[1];
        cfg.leftHigh <= regWdata[2];
        cfg.wide16   <= regWdata[3];
        cfg.mode     <= regWdata[5:4];
        cfg.halfDiv  <= regWdata[15:8];
        cfg.slotBits <= regWdata[21:16];
      end
      if (regRd) begin
        case (regAddr)
          A_CFG:   regRdata <= DATA_W'({cfg.slotBits, cfg.halfDiv, 2'b00, cfg.mode,
                                        cfg.wide16, cfg.leftHigh, cfg.master, cfg.active});
          A_STAT:  regRdata <= DATA_W'({overflow, pairCount});
          A_DATA:  regRdata <= fifoEmpty ? '0 : fifoHead;
          default: regRdata <= '0;
        endcase
      end
    end
  end

  // master clock generation
  logic       genRun, sclkReg, wsReg, masterRise;
  logic [7:0] divCnt, halfEff;
  logic [5:0] slotCnt, slotEff;

  assign genRun  = cfg.active && cfg.master;
  assign halfEff = (cfg.halfDiv == 8'd0) ? 8'd1 : cfg.halfDiv;
  assign slotEff = (cfg.slotBits == 6'd0) ? 6'd1 : cfg.slotBits;
  assign masterRise = genRun && (divCnt == halfEff - 8'd1) && !sclkReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      sclkReg <= 1'b0;
      wsReg   <= 1'b0;
      slotCnt <= '0;
    end else if (!genRun) begin
      divCnt  <= '0;
      sclkReg <= 1'b0;
      wsReg   <= 1'b0;
      slotCnt <= '0;
    end else if (divCnt == halfEff - 8'd1) begin
      divCnt  <= '0;
      sclkReg <= ~sclkReg;
      if (sclkReg) begin
        if (slotCnt == slotEff - 6'd1) begin
          slotCnt <= '0;
          wsReg   <= ~wsReg;
        end else begin
          slotCnt <= slotCnt + 6'd1;
        end
      end
    end else begin
      divCnt <= divCnt + 8'd1;
    end
  end

  assign sclkOut  = sclkReg;
  assign wsOut    = wsReg;
  assign clkDrvEn = cfg.master;

  // input synchronizers
  logic [SYNC_N-1:0] sclkSyn, wsSyn, sdSyn;
  logic              sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSyn  <= '0;
      wsSyn    <= '0;
      sdSyn    <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSyn  <= {sclkSyn[SYNC_N-2:0], sclkIn};
      wsSyn    <= {wsSyn[SYNC_N-2:0], wsIn};
      sdSyn    <= {sdSyn[SYNC_N-2:0], sdIn};
      sclkPrev <= sclkSyn[SYNC_N-1];
    end
  end

  logic rise, wsNow, sdNow, rxOn;
  assign sdNow = sdSyn[SYNC_N-1];
  assign rise  = cfg.master ? masterRise : (sclkSyn[SYNC_N-1] && !sclkPrev);
  assign wsNow = cfg.master ? wsReg : wsSyn[SYNC_N-1];
  assign rxOn  = cfg.active && rxModeOn(cfg.mode);

  // serial capture
  logic                wsKnown, prevWs, armed, wsChange;
  logic [SAMPLE_W-1:0] shreg, finalWord;
  logic [BIT_W-1:0]    bitCnt, wLen;

  assign wLen     = cfg.wide16 ? BIT_W'(16) : BIT_W'(8);
  assign wsChange = rxOn && rise && wsKnown && (wsNow != prevWs);

  always_comb begin
    finalWord = (bitCnt < wLen) ? {shreg[SAMPLE_W-2:0], sdNow} : shreg;
    if (!cfg.wide16) finalWord = finalWord & SAMPLE_W'(16'h00FF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wsKnown <= 1'b0;
      prevWs  <= 1'b0;
      armed   <= 1'b0;
      shreg   <= '0;
      bitCnt  <= '0;
    end else if (!rxOn || flushReq) begin
      wsKnown <= 1'b0;
      armed   <= 1'b0;
      shreg   <= '0;
      bitCnt  <= '0;
    end else if (rise) begin
      if (!wsKnown) begin
        wsKnown <= 1'b1;
        prevWs  <= wsNow;
      end else if (wsNow != prevWs) begin
        prevWs <= wsNow;
        armed  <= 1'b1;
        shreg  <= '0;
        bitCnt <= '0;
      end else if (bitCnt < wLen) begin
        shreg  <= {shreg[SAMPLE_W-2:0], sdNow};
        bitCnt <= bitCnt + BIT_W'(1);
      end
    end
  end

  always_comb begin
    strobe.pushLeft  = wsChange && armed && (prevWs == cfg.leftHigh);
    strobe.pushRight = wsChange && armed && (prevWs != cfg.leftHigh);
    strobe.flush     = flushReq;
    strobe.pop       = popReq;
    strobe.sample    = finalWord;
  end

  // word select only moves on a falling generated bit clock (R10)
  p_ws_on_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (genRun && $past(genRun) && !$stable(wsOut)) |-> $fell(sclkOut));

  // slave mode keeps the bit-clock output quiet (R12)
  p_slave_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.master |=> !sclkOut);

  // shift counter never exceeds the longest sample (R4)
  p_shift_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_W'(SAMPLE_W));

endmodule

// File: rtl/i2s_rx_dp.sv
module i2s_rx_dp
  import i2s_rx_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  output logic [CNT_W-1:0]  pairCount,
  output logic              overflow,
  output logic [DATA_W-1:0] fifoHead,
  output logic              fifoEmpty,
  output logic              dmaReq
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wrPtr, rdPtr, wrNext, words, freeWords;
  logic              haveLeft, roomForPair;
  logic [DATA_W-1:0] sampleExt;

  assign wrNext      = wrPtr + PW'(1);
  assign words       = wrPtr - rdPtr;
  assign freeWords   = DEPTH_P - words;
  assign roomForPair = freeWords >= PW'(2);
  assign sampleExt   = DATA_W'(strobe.sample);

  always_ff @(posedge clk) begin
    if (!strobe.flush) begin
      if (strobe.pushLeft && roomForPair) mem[wrPtr[AW-1:0]] <= sampleExt;
      if (strobe.pushRight && haveLeft)   mem[wrNext[AW-1:0]] <= sampleExt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      haveLeft <= 1'b0;
      overflow <= 1'b0;
    end else if (strobe.flush) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      haveLeft <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (strobe.pushLeft) begin
        if (roomForPair) begin
          haveLeft <= 1'b1;
        end else begin
          haveLeft <= 1'b0;
          overflow <= 1'b1;
        end
      end
      if (strobe.pushRight) begin
        if (haveLeft) wrPtr <= wrPtr + PW'(2);
        haveLeft <= 1'b0;
      end
      if (strobe.pop && words != '0) rdPtr <= rdPtr + PW'(1);
    end
  end

  assign pairCount = CNT_W'(words >> 1);
  assign fifoEmpty = (words == '0);
  assign fifoHead  = mem[rdPtr[AW-1:0]];
  assign dmaReq    = words >= PW'(2);

  // committed region grows only by whole pairs (R3)
  p_pair_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr != $past(wrPtr)) |-> (wrPtr == $past(wrPtr) + PW'(2) || wrPtr == '0));

  // occupancy never exceeds the storage (R8)
  p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    words <= DEPTH_P);

  // overflow flag is sticky until flush (R8)
  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !strobe.flush) |=> overflow);

  // flush empties everything (R9)
  p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (words == '0 && !overflow && !haveLeft));

  // request tracks presence of a full pair (R7)
  p_dma_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq == (pairCount != '0));

endmodule

// File: rtl/i2s_rx_channel.sv
module i2s_rx_channel
  import i2s_rx_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sclkIn,
  input  logic              wsIn,
  input  logic              sdIn,
  output logic              sclkOut,
  output logic              wsOut,
  output logic              clkDrvEn,
  output logic              dmaReq
);

  rxStrobe_t         strobe;
  logic [CNT_W-1:0]  pairCount;
  logic              overflow, fifoEmpty;
  logic [DATA_W-1:0] fifoHead;

  i2s_rx_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .pairCount(pairCount), .overflow(overflow),
    .fifoHead(fifoHead), .fifoEmpty(fifoEmpty),
    .sclkIn(sclkIn), .wsIn(wsIn), .sdIn(sdIn),
    .sclkOut(sclkOut), .wsOut(wsOut), .clkDrvEn(clkDrvEn),
    .strobe(strobe)
  );

  i2s_rx_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pairCount(pairCount), .overflow(overflow),
    .fifoHead(fifoHead), .fifoEmpty(fifoEmpty), .dmaReq(dmaReq)
  );

endmodule

// File: tb/i2s_rx_channel_tb_top.sv
`timescale 1ns/1ps
module i2s_rx_channel_tb_top;

  localparam int GH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        sdIn = 1'b0;
  logic        sclkOut, wsOut, clkDrvEn, dmaReq;
  logic        genSclk = 1'b1, genWs = 1'b0;

  int nChecks = 0, nFails = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2s_rx_channel dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclkIn(genSclk), .wsIn(genWs),
    .sdIn(sdIn), .sclkOut(sclkOut), .wsOut(wsOut), .clkDrvEn(clkDrvEn), .dmaReq(dmaReq)
  );

  function automatic logic [15:0] sampleVal(input int ch, input int idx, input int w);
    logic [15:0] v;
    v = 16'hA5C3 ^ 16'(idx * 32'h1F3B) ^ ((ch != 0) ? 16'h5A5A : 16'h0000);
    if (w == 8) v = v & 16'h00FF;
    return v;
  endfunction

  function automatic logic [31:0] cfgWord(input bit act, input bit mst, input bit pol,
                                          input bit wide, input logic [1:0] mode,
                                          input int half, input int slot);
    return {10'b0, 6'(slot), 8'(half), 2'b0, mode, wide, pol, mst, act};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // serial transmitter model
  bit   useMaster = 0, txPol = 0, pendLoad = 0, lastSclk = 1, lastWsF = 0;
  int   txW = 16, txPos = 0, leftIdx = 0;
  logic [15:0] txWord = '0;
  logic curS, curW;

  always @(negedge clk) begin
    curS = useMaster ? sclkOut : genSclk;
    curW = useMaster ? wsOut : genWs;
    if (lastSclk && !curS) begin
      if (pendLoad) begin
        if (curW == txPol) begin
          txWord = sampleVal(0, leftIdx, txW);
          leftIdx++;
        end else begin
          txWord = sampleVal(1, leftIdx - 1, txW);
        end
        txPos = 0;
      end else begin
        txPos++;
      end
      sdIn = (txPos < txW) ? txWord[txW-1-txPos] : 1'b0;
      pendLoad = (curW != lastWsF);
      lastWsF = curW;
    end
    lastSclk = curS;
  end

  task automatic txReset(input bit mst, input bit pol, input int w);
    @(posedge clk);
    useMaster = mst; txPol = pol; txW = w;
    pendLoad = 0; leftIdx = 0; txPos = 0;
    lastSclk = mst ? 1'b0 : genSclk;
    lastWsF  = mst ? 1'b0 : genWs;
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regRd = 1; regAddr = a;
    @(negedge clk); regRd = 0; d = regRdata;
  endtask

  task automatic genBit(input logic ws);
    @(negedge clk); #1; genSclk = 0; genWs = ws;
    repeat (GH) @(negedge clk);
    #1; genSclk = 1;
    repeat (GH - 1) @(negedge clk);
  endtask

  task automatic genFrames(input int n, input int slot, input bit pol);
    for (int i = 0; i < 3; i++) genBit(!pol);
    for (int f = 0; f < n; f++) begin
      for (int b = 0; b < slot; b++) genBit(pol);
      for (int b = 0; b < slot; b++) genBit(!pol);
    end
    for (int b = 0; b < slot; b++) genBit(pol);
    for (int b = 0; b < 3; b++) genBit(!pol);
    repeat (10) @(negedge clk);
  endtask

  task automatic readPairs(input string req, input int n, input int w);
    logic [31:0] d;
    for (int f = 0; f < n; f++) begin
      rdReg(3'd2, d); check({req, " left"},  d, {16'b0, sampleVal(0, f, w)});
      rdReg(3'd2, d); check({req, " right"}, d, {16'b0, sampleVal(1, f, w)});
    end
  endtask

  task automatic stopAndFlush();
    wrReg(3'd0, 32'h0);
    wrReg(3'd1, 32'h1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    int c, r1, r2, w1, w2;
    bit prevS, prevW;

    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R1: reset state
    rdReg(3'd1, d); check("R1 status", d, 32'h0);
    check("R1 dmaReq", {31'b0, dmaReq}, 32'h0);
    check("R1 sclkOut", {31'b0, sclkOut}, 32'h0);
    check("R1 wsOut", {31'b0, wsOut}, 32'h0);
    check("R1 clkDrvEn", {31'b0, clkDrvEn}, 32'h0);

    // T1: slave, 16-bit, ws low = left, receive only; trailing lone left
    wrReg(3'd1, 32'h1);
    txReset(0, 0, 16);
    wrReg(3'd0, cfgWord(1, 0, 0, 1, 2'b01, 4, 16));
    genFrames(5, 16, 0);
    rdReg(3'd1, d); check("R3 count with lone left", d, 32'd5);
    check("R7 dmaReq with pairs", {31'b0, dmaReq}, 32'h1);
    check("R12 sclkOut quiet in slave", {31'b0, sclkOut}, 32'h0);
    check("R12 clkDrvEn low in slave", {31'b0, clkDrvEn}, 32'h0);
    rdReg(3'd2, d); check("R6 first word left", d, {16'b0, sampleVal(0, 0, 16)});
    rdReg(3'd1, d); check("R6 count after pop", d, 32'd4);
    rdReg(3'd2, d); check("R6 then right", d, {16'b0, sampleVal(1, 0, 16)});
    for (int f = 1; f < 5; f++) begin
      rdReg(3'd2, d); check("R2 R4 left", d, {16'b0, sampleVal(0, f, 16)});
      rdReg(3'd2, d); check("R2 R4 right", d, {16'b0, sampleVal(1, f, 16)});
    end
    check("R7 dmaReq empty", {31'b0, dmaReq}, 32'h0);
    rdReg(3'd2, d); check("R6 empty read", d, 32'h0);
    rdReg(3'd1, d); check("R6 empty count", d, 32'h0);

    // T2: flush drops pending left and re-arms
    wrReg(3'd1, 32'h1);
    txReset(0, 0, 16);
    genFrames(3, 16, 0);
    rdReg(3'd1, d); check("R9 count after flush restart", d, 32'd3);
    readPairs("R9 stream after flush", 3, 16);

    // T3: slave, 8-bit in 16-bit slot, ws high = left, duplex mode
    stopAndFlush();
    txReset(0, 1, 8);
    wrReg(3'd0, cfgWord(1, 0, 1, 0, 2'b10, 4, 16));
    genFrames(4, 16, 1);
    rdReg(3'd1, d); check("R5 R11 count", d, 32'd4);
    readPairs("R4 R5 8-bit aligned", 4, 8);

    // T4: mode 00 captures nothing
    stopAndFlush();
    txReset(0, 0, 16);
    wrReg(3'd0, cfgWord(1, 0, 0, 1, 2'b00, 4, 16));
    genFrames(2, 16, 0);
    rdReg(3'd1, d); check("R11 mode 00 count", d, 32'h0);
    check("R11 mode 00 dmaReq", {31'b0, dmaReq}, 32'h0);
    rdReg(3'd2, d); check("R11 mode 00 data", d, 32'h0);

    // T5: overflow with 8-bit slots
    stopAndFlush();
    txReset(0, 0, 8);
    wrReg(3'd0, cfgWord(1, 0, 0, 0, 2'b01, 4, 8));
    genFrames(34, 8, 0);
    rdReg(3'd1, d); check("R8 full with overflow", d, 32'h0001_0020);
    readPairs("R8 kept oldest pairs", 32, 8);
    rdReg(3'd1, d); check("R8 overflow sticky", d, 32'h0001_0000);
    wrReg(3'd1, 32'h1);
    rdReg(3'd1, d); check("R9 flush clears overflow", d, 32'h0);

    // T6: master mode
    stopAndFlush();
    txReset(1, 0, 16);
    wrReg(3'd0, cfgWord(1, 1, 0, 1, 2'b01, 4, 16));
    check("R10 clkDrvEn", {31'b0, clkDrvEn}, 32'h1);
    r1 = -1; r2 = -1; w1 = -1; w2 = -1;
    prevS = sclkOut; prevW = wsOut;
    while (w2 < 0) begin
      @(negedge clk);
      if (sclkOut && !prevS) begin
        if (r1 < 0) r1 = cyc; else if (r2 < 0) r2 = cyc;
      end
      if (wsOut != prevW) begin
        if (w1 < 0) w1 = cyc; else w2 = cyc;
      end
      prevS = sclkOut; prevW = wsOut;
    end
    check("R10 bit clock period", 32'(r2 - r1), 32'd8);
    check("R10 word select spacing", 32'(w2 - w1), 32'd128);
    repeat (2000) @(negedge clk);
    wrReg(3'd0, cfgWord(0, 1, 0, 1, 2'b01, 4, 16));
    rdReg(3'd1, d);
    c = int'(d[15:0]);
    check("R10 master pairs captured", {31'b0, (c >= 4)}, 32'h1);
    readPairs("R10 master data", c, 16);
    rdReg(3'd1, d); check("R10 drained", d, 32'h0);

    finishRun();
  end

endmodule